// File: doc/BRIEF.md
# Statistics counter read-modify-write engine

This block keeps a large table of paired event counters in an external word-addressed memory. Each stored word holds a packet count and a byte count for one counter slot. A client sends requests over a valid/ready handshake. An update request adds a packet increment and a byte increment to one slot. A readback request returns the slot's current counts on a response port and leaves the slot at zero. Every request becomes a read-modify-write on a single memory word. The memory has a fixed read latency, so the block pipelines the read, the add and the write-back, and it accepts a new request every cycle until its in-flight limit is reached.

Because several requests to the same slot can be in flight at once, an address comparator sits in front of the adder. It compares the slot being written back with every write-back of the last read-latency cycles. When it finds a match, it uses the newest such value in place of the stale word the memory returned, so back-to-back increments all accumulate. A readback-and-clear takes part in the same forwarding path. Its zero write is forwarded to any later update of that slot.

Each count saturates at its maximum value instead of wrapping. The memory itself is outside the block: it is reached through a read port, whose data arrives a fixed number of cycles after the address, and a write port.

Top module: `cnt_rmw_engine`

## Requirements
- R1: An accepted update writes back to the same address the stored word with the packet increment added to the packet field and the byte increment added to the byte field.
- R2: The stored word holds the packet count in bits [PKT_W+BYTE_W-1:BYTE_W] (71:40 by default) and the byte count in bits [BYTE_W-1:0] (39:0 by default).
- R3: A readback accepted in cycle t raises rsp_valid for exactly one cycle in cycle t+RD_LAT+1. The response carries the address, rsp_pkt and rsp_byte. rsp_valid never rises for an update.
- R4: An accepted readback writes an all-zero word to its address.
- R5: Updates to an address that still has an earlier request in flight lose no increment: the final stored counts equal the sum of all increments, for back-to-back and interleaved address patterns.
- R6: A readback returns the effect of every request to its address that was accepted before it. An update to that address accepted after the readback starts from zero.
- R7: Each field saturates on its own at its all-ones value (packet 32'hFFFF_FFFF, byte 40'hFF_FFFF_FFFF by default) instead of wrapping, and the other field is unaffected.
- R8: req_ready is low during reset. After reset it is low exactly when accepting a request would leave more than MAX_INFLIGHT requests in flight. While req_valid is high and req_ready is low, no request is accepted and no memory read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_readback | input | 1 | 1 = readback and clear, 0 = update |
| req_addr | input | ADDR_W | Counter slot address |
| req_pkt_inc | input | PINC_W | Packet count increment (updates only) |
| req_byte_inc | input | BINC_W | Byte count increment (updates only) |
| rsp_valid | output | 1 | Readback result present for one cycle |
| rsp_addr | output | ADDR_W | Address of the readback result |
| rsp_pkt | output | PKT_W | Packet count read back |
| rsp_byte | output | BYTE_W | Byte count read back |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | PKT_W+BYTE_W | Read data, valid RD_LAT cycles after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | PKT_W+BYTE_W | Memory write data |

## Verification
The bench builds the engine with ADDR_W=6, so a 64-word memory model can stand in for the full four-million-slot table. It keeps the default read latency of 4 and lowers MAX_INFLIGHT to 3, one below the latency. This makes req_ready drop during runs of back-to-back requests, so throttling is exercised along with forwarding across a stall gap. With these values, five requests to one slot, interleaved pairs of slots, and a readback placed between two updates all fall inside one forwarding window. Preloading words near full scale brings saturation of each field within reach.

// File: rtl/cnt_rmw_pkg.sv
package cnt_rmw_pkg;

  typedef enum logic {
    OP_UPDATE   = 1'b0,
    OP_READBACK = 1'b1
  } cnt_op_e;

endpackage

// File: rtl/cnt_req_pipe.sv
// Request pipeline: one stage per cycle of memory read latency, plus
// occupancy tracking that drives the input handshake.
module cnt_req_pipe
  import cnt_rmw_pkg::*;
#(
  parameter int ADDR_W      = 22,
  parameter int PINC_W      = 16,
  parameter int BINC_W      = 24,
  parameter int RD_LAT      = 4,
  parameter int MAX_INFLIGHT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  cnt_op_e           in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [PINC_W-1:0] in_pinc,
  input  logic [BINC_W-1:0] in_binc,
  output logic              in_ready,
  output logic              accept,
  output logic              tail_valid,
  output cnt_op_e           tail_op,
  output logic [ADDR_W-1:0] tail_addr,
  output logic [PINC_W-1:0] tail_pinc,
  output logic [BINC_W-1:0] tail_binc
);

  localparam int CW = $clog2(RD_LAT + 2);
  localparam logic [CW-1:0] MAX_C = CW'(MAX_INFLIGHT);

  logic [RD_LAT-1:0] vld_q, vld_d;
  cnt_op_e           op_q   [RD_LAT];
  logic [ADDR_W-1:0] addr_q [RD_LAT];
  logic [PINC_W-1:0] pinc_q [RD_LAT];
  logic [BINC_W-1:0] binc_q [RD_LAT];
  logic [CW-1:0]     total;
  logic [CW-1:0]     staying;

  // occupancy: entries that remain in the pipe after this cycle
  always_comb begin
    total = '0;
    for (int k = 0; k < RD_LAT; k++) total = total + CW'(vld_q[k]);
    staying  = total - CW'(vld_q[RD_LAT-1]);
    in_ready = rst_n && (staying < MAX_C);
    accept   = in_valid && in_ready;
  end

  always_comb begin
    vld_d[0] = accept;
    for (int k = 1; k < RD_LAT; k++) vld_d[k] = vld_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  generate
    for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (accept) begin
            op_q[0]   <= in_op;
            addr_q[0] <= in_addr;
            pinc_q[0] <= in_pinc;
            binc_q[0] <= in_binc;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (vld_q[s-1]) begin
            op_q[s]   <= op_q[s-1];
            addr_q[s] <= addr_q[s-1];
            pinc_q[s] <= pinc_q[s-1];
            binc_q[s] <= binc_q[s-1];
          end
        end
      end
    end
  endgenerate

  assign tail_valid = vld_q[RD_LAT-1];
  assign tail_op    = op_q[RD_LAT-1];
  assign tail_addr  = addr_q[RD_LAT-1];
  assign tail_pinc  = pinc_q[RD_LAT-1];
  assign tail_binc  = binc_q[RD_LAT-1];

  assert_occupancy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    total <= MAX_C)
    else $error("in-flight count above limit");

  assert_hold_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> !vld_q[0])
    else $error("request entered while not ready");

endmodule

// File: rtl/cnt_fwd_cmp.sv
// Write-back history and address comparator: replaces stale read data with
// the newest value written to the same address during the read window.
module cnt_fwd_cmp #(
  parameter int ADDR_W = 22,
  parameter int WORD_W = 72,
  parameter int RD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] look_addr,
  input  logic [WORD_W-1:0] mem_data,
  output logic [WORD_W-1:0] base
);

  logic [RD_LAT-1:0] hv_q, hv_d;
  logic [ADDR_W-1:0] ha_q [RD_LAT];
  logic [WORD_W-1:0] hd_q [RD_LAT];

  always_comb begin
    hv_d[0] = wr_en;
    for (int k = 1; k < RD_LAT; k++) hv_d[k] = hv_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hv_q <= '0;
    else        hv_q <= hv_d;
  end

  generate
    for (genvar s = 0; s < RD_LAT; s++) begin : g_hist
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (wr_en) begin
            ha_q[0] <= wr_addr;
            hd_q[0] <= wr_data;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (hv_q[s-1]) begin
            ha_q[s] <= ha_q[s-1];
            hd_q[s] <= hd_q[s-1];
          end
        end
      end
    end
  endgenerate

  // newest matching write (lowest index) wins
  always_comb begin
    base = mem_data;
    for (int k = RD_LAT - 1; k >= 0; k--) begin
      if (hv_q[k] && (ha_q[k] == look_addr)) base = hd_q[k];
    end
  end

endmodule

// File: rtl/cnt_sat_add.sv
// Adds the two increments to their fields, each clamped at all-ones.
module cnt_sat_add #(
  parameter int PKT_W  = 32,
  parameter int BYTE_W = 40,
  parameter int PINC_W = 16,
  parameter int BINC_W = 24
) (
  input  logic [PKT_W+BYTE_W-1:0] base,
  input  logic [PINC_W-1:0]       pinc,
  input  logic [BINC_W-1:0]       binc,
  output logic [PKT_W+BYTE_W-1:0] sum
);

  logic [PKT_W:0]  pkt_ext;
  logic [BYTE_W:0] byte_ext;

  always_comb begin
    pkt_ext  = {1'b0, base[PKT_W+BYTE_W-1:BYTE_W]} + (PKT_W+1)'(pinc);
    byte_ext = {1'b0, base[BYTE_W-1:0]} + (BYTE_W+1)'(binc);
    sum[PKT_W+BYTE_W-1:BYTE_W] = pkt_ext[PKT_W]   ? '1 : pkt_ext[PKT_W-1:0];
    sum[BYTE_W-1:0]            = byte_ext[BYTE_W] ? '1 : byte_ext[BYTE_W-1:0];
  end

endmodule

// File: rtl/cnt_rmw_engine.sv
module cnt_rmw_engine
  import cnt_rmw_pkg::*;
#(
  parameter int ADDR_W       = 22,
  parameter int PKT_W        = 32,
  parameter int BYTE_W       = 40,
  parameter int PINC_W       = 16,
  parameter int BINC_W       = 24,
  parameter int RD_LAT       = 4,
  parameter int MAX_INFLIGHT = 4,
  localparam int WORD_W      = PKT_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_readback,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PINC_W-1:0] req_pkt_inc,
  input  logic [BINC_W-1:0] req_byte_inc,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [PKT_W-1:0]  rsp_pkt,
  output logic [BYTE_W-1:0] rsp_byte,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data
);

  // reset: asserts at once, releases after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_ok_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok_n = rst_sync_q[1];

  logic              accept;
  logic              tail_valid;
  cnt_op_e           tail_op;
  logic [ADDR_W-1:0] tail_addr;
  logic [PINC_W-1:0] tail_pinc;
  logic [BINC_W-1:0] tail_binc;
  logic [WORD_W-1:0] base_word;
  logic [WORD_W-1:0] sum_word;
  logic              tail_rb;

  cnt_req_pipe #(
    .ADDR_W(ADDR_W), .PINC_W(PINC_W), .BINC_W(BINC_W),
    .RD_LAT(RD_LAT), .MAX_INFLIGHT(MAX_INFLIGHT)
  ) u_pipe (
    .clk        (clk),
    .rst_n      (rst_ok_n),
    .in_valid   (req_valid),
    .in_op      (cnt_op_e'(req_readback)),
    .in_addr    (req_addr),
    .in_pinc    (req_pkt_inc),
    .in_binc    (req_byte_inc),
    .in_ready   (req_ready),
    .accept     (accept),
    .tail_valid (tail_valid),
    .tail_op    (tail_op),
    .tail_addr  (tail_addr),
    .tail_pinc  (tail_pinc),
    .tail_binc  (tail_binc)
  );

  assign mem_rd_en   = accept;
  assign mem_rd_addr = req_addr;

  cnt_fwd_cmp #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .RD_LAT(RD_LAT)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .wr_en     (mem_wr_en),
    .wr_addr   (mem_wr_addr),
    .wr_data   (mem_wr_data),
    .look_addr (tail_addr),
    .mem_data  (mem_rd_data),
    .base      (base_word)
  );

  cnt_sat_add #(
    .PKT_W(PKT_W), .BYTE_W(BYTE_W), .PINC_W(PINC_W), .BINC_W(BINC_W)
  ) u_add (
    .base (base_word),
    .pinc (tail_pinc),
    .binc (tail_binc),
    .sum  (sum_word)
  );

  assign tail_rb     = (tail_op == OP_READBACK);
  assign mem_wr_en   = tail_valid;
  assign mem_wr_addr = tail_addr;
  assign mem_wr_data = tail_rb ? '0 : sum_word;

  // response register
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_load;
  logic [ADDR_W-1:0] rsp_addr_q;
  logic [WORD_W-1:0] rsp_word_q;

  always_comb begin
    rsp_load    = tail_valid && tail_rb;
    rsp_valid_d = rsp_load;
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) rsp_valid_q <= 1'b0;
    else           rsp_valid_q <= rsp_valid_d;
  end

  always_ff @(posedge clk) begin
    if (rsp_load) begin
      rsp_addr_q <= tail_addr;
      rsp_word_q <= base_word;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_addr  = rsp_addr_q;
  assign rsp_pkt   = rsp_word_q[WORD_W-1:BYTE_W];
  assign rsp_byte  = rsp_word_q[BYTE_W-1:0];

  assert_rsp_from_readback_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rsp_valid |-> $past(tail_valid && tail_rb))
    else $error("response without readback");

  assert_clear_word_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (tail_valid && tail_rb) |-> (mem_wr_en && mem_wr_data == '0))
    else $error("readback did not clear");

  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (tail_valid && !tail_rb) |->
      (mem_wr_data[WORD_W-1:BYTE_W] >= base_word[WORD_W-1:BYTE_W] &&
       mem_wr_data[BYTE_W-1:0] >= base_word[BYTE_W-1:0]))
    else $error("counter wrapped");

  assert_rd_only_on_ready_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mem_rd_en |-> req_ready)
    else $error("read issued while not ready");

endmodule

// File: tb/cnt_rmw_engine_bench.sv
module cnt_rmw_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 6;
  localparam int LAT  = 4;
  localparam int MAXF = 3;
  localparam int WW   = 72;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_readback;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_pkt_inc;
  logic [23:0]   req_byte_inc;
  logic          rsp_valid;
  logic [AW-1:0] rsp_addr;
  logic [31:0]   rsp_pkt;
  logic [39:0]   rsp_byte;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [WW-1:0] mem_rd_data, mem_wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_rmw_engine #(.ADDR_W(AW), .RD_LAT(LAT), .MAX_INFLIGHT(MAXF)) u_cnt_rmw_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_readback(req_readback), .req_addr(req_addr), .req_pkt_inc(req_pkt_inc),
    .req_byte_inc(req_byte_inc), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_pkt(rsp_pkt), .rsp_byte(rsp_byte), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  // memory model with fixed read latency
  logic [WW-1:0] mem [64];
  logic [WW-1:0] rdq [LAT];
  logic          pre_en;
  logic [AW-1:0] pre_addr;
  logic [WW-1:0] pre_data;

  always @(posedge clk) begin
    if (pre_en) mem[pre_addr] <= pre_data;
    else if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    rdq[0] <= mem_rd_en ? mem[mem_rd_addr] : '0;
    for (int k = 1; k < LAT; k++) rdq[k] <= rdq[k-1];
  end
  assign mem_rd_data = rdq[LAT-1];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [WW-1:0] q_w [$];
  logic [AW-1:0] q_a [$];
  int            q_c [$];
  always @(negedge clk) begin
    if (rsp_valid) begin
      q_w.push_back({rsp_pkt, rsp_byte});
      q_a.push_back(rsp_addr);
      q_c.push_back(cyc);
    end
  end

  int n_chk = 0, n_fail = 0, stalls = 0, acc_cyc = 0;
  bit done = 0;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic rb, logic [AW-1:0] a, logic [15:0] p, logic [23:0] b);
    req_valid = 1'b1; req_readback = rb; req_addr = a;
    req_pkt_inc = p; req_byte_inc = b;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
    end
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic preload(logic [AW-1:0] a, logic [WW-1:0] d);
    pre_en = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic chk_rsp(string tag, logic [AW-1:0] a, logic [31:0] p, logic [39:0] b);
    if (q_w.size() == 0) begin
      chk({tag, " missing response"}, 1, 0);
    end else begin
      chk({tag, " addr"}, q_a.pop_front(), a);
      chk({tag, " counts"}, q_w.pop_front(), {p, b});
      void'(q_c.pop_front());
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_readback = 1'b0;
    req_addr = '0; req_pkt_inc = '0; req_byte_inc = '0; pre_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) preload(AW'(i), '0);
    chk("R8 ready low in reset", req_ready, 0);
    chk("R3 no response in reset", rsp_valid, 0);
    chk("R1 no write in reset", mem_wr_en, 0);
    rst_n = 1'b1;
    idle(4);
    chk("R8 ready after reset", req_ready, 1);
  endtask

  task automatic t_single;
    int a_cyc;
    send(0, 6'd5, 16'd3, 24'd100);
    idle(8);
    chk("R1 R2 stored word", mem[5], {32'd3, 40'd100});
    send(1, 6'd5, 16'd0, 24'd0);
    a_cyc = acc_cyc;
    idle(8);
    if (q_c.size() != 0) chk("R3 response latency", q_c[0] - a_cyc, LAT + 1);
    else chk("R3 response latency", 0, LAT + 1);
    chk_rsp("R3 readback", 6'd5, 32'd3, 40'd100);
    chk("R3 single response", q_w.size(), 0);
    chk("R4 cleared word", mem[5], '0);
  endtask

  task automatic t_merge;
    send(0, 6'd9, 16'd1, 24'd10);
    send(0, 6'd9, 16'd2, 24'd20);
    send(0, 6'd9, 16'd3, 24'd30);
    send(0, 6'd9, 16'd4, 24'd40);
    send(1, 6'd9, 16'd0, 24'd0);
    idle(10);
    chk_rsp("R5 back-to-back merge", 6'd9, 32'd10, 40'd100);
    chk("R5 R4 merged slot cleared", mem[9], '0);
  endtask

  task automatic t_interleave;
    send(0, 6'd20, 16'd1, 24'd1);
    send(0, 6'd21, 16'd2, 24'd5);
    send(0, 6'd20, 16'd1, 24'd1);
    send(0, 6'd21, 16'd2, 24'd5);
    send(0, 6'd20, 16'd1, 24'd1);
    idle(8);
    chk("R5 interleaved A", mem[20], {32'd3, 40'd3});
    chk("R5 interleaved B", mem[21], {32'd4, 40'd10});
    send(1, 6'd20, 16'd0, 24'd0);
    send(1, 6'd21, 16'd0, 24'd0);
    idle(8);
    chk_rsp("R5 readback A", 6'd20, 32'd3, 40'd3);
    chk_rsp("R5 readback B", 6'd21, 32'd4, 40'd10);
  endtask

  task automatic t_rb_mid;
    send(0, 6'd30, 16'd1, 24'd7);
    send(1, 6'd30, 16'd0, 24'd0);
    send(0, 6'd30, 16'd2, 24'd9);
    idle(8);
    chk_rsp("R6 readback sees earlier update", 6'd30, 32'd1, 40'd7);
    chk("R6 later update from zero", mem[30], {32'd2, 40'd9});
  endtask

  task automatic t_sat;
    preload(6'd40, {32'hFFFF_FFF0, 40'hFF_FFFF_FF00});
    preload(6'd41, {32'h0000_0005, 40'hFF_FFFF_FFF0});
    send(0, 6'd40, 16'h20, 24'h0);
    send(0, 6'd41, 16'h1, 24'h100);
    idle(8);
    chk("R7 packet saturates", mem[40], {32'hFFFF_FFFF, 40'hFF_FFFF_FF00});
    chk("R7 byte saturates", mem[41], {32'h0000_0006, 40'hFF_FFFF_FFFF});
  endtask

  task automatic t_throttle;
    int s0;
    s0 = stalls;
    for (int i = 0; i < 7; i++) send(0, AW'(50 + i), 16'(i + 1), 24'(i + 2));
    idle(8);
    chk("R8 stall cycles", stalls - s0, 2);
    for (int i = 0; i < 7; i++)
      chk("R8 R1 throttled writes", mem[50 + i], {32'(i + 1), 40'(i + 2)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_single;
    t_merge;
    t_interleave;
    t_rb_mid;
    t_sat;
    t_throttle;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule